// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It walks a two-level translation structure that lives in ordinary memory. The ten most significant address bits select an entry in the top-level directory page. The next ten bits select an entry in the second-level table page. The low twelve bits pass through as the byte offset inside a 4 KB page. Every entry is one 32-bit word. Its upper twenty bits name a page frame and its lower twelve bits carry flags. Flag positions used throughout are: bit 0 present, bit 1 writable, bit 2 user-accessible, bit 5 accessed, bit 6 dirty, and bits 11:9 reserved for software.

A requester hands over an address, a read/write indication and the privilege ring of the access (ring 3 is the unprivileged ring). The walker then fetches the two entries one memory read at a time. It checks permissions and, when the translation succeeds, writes back any accessed or dirty bits that were still clear. It finishes with a one-cycle result that carries either the physical address or a 3-bit fault code. In the fault code, bit 2 tells the level (0 = directory, 1 = table) and bits 1:0 tell the cause: 00 none, 01 not present, 10 write-protect, 11 user-privilege.

The directory base frame sits in a root register. Only ring-0 write requests may change it. Memory uses a simple request/acknowledge handshake with one transaction in flight.

Top module: `pgw_top`

## Requirements
- R1: The directory read goes to root frame × 4096 + address[31:22] × 4, and the table read goes to directory-entry frame × 4096 + address[21:12] × 4.
- R2: A successful walk returns physical address = {table-entry bits 31:12, address bits 11:0}, with done_fault low and done_fcode 000.
- R3: A root write with ring 0 loads the root frame, so the next walk uses the new frame. A root write with any other ring leaves the root unchanged, and root_wr_denied is high for exactly the following cycle.
- R4: A clear present bit (bit 0) in the directory entry faults with code 001, and no table read is issued. A clear present bit in the table entry faults with code 101. A faulting walk reports physical address 0.
- R5: A ring-3 access needs the user bit (bit 2) set in both entries. If the directory entry lacks it the code is 011; if only the table entry lacks it the code is 111. Rings 0 to 2 ignore the user bit.
- R6: A write access at any ring needs the writable bit (bit 1) set in both entries. If the directory entry lacks it the code is 010; if only the table entry lacks it the code is 110. A user-privilege fault takes priority over a write-protect fault.
- R7: After a successful walk, a directory entry with accessed clear is written back with bit 5 set. A table entry is written back with bit 5 set, and with bit 6 also set for a write, whenever one of those bits was clear. The directory write-back comes before the table write-back.
- R8: No memory write is issued when the needed accessed/dirty bits are already set, and a faulting walk issues no memory write.
- R9: Write-back data equals the entry as read, with only bits 5 and 6 forced on. All other bits, including software bits 11:9 and the frame, are kept unchanged.
- R10: mem_req stays high with stable address, write enable and data until mem_ack. Only one memory request is outstanding at a time, and req_ready is high only while no walk is in progress.
- R11: After reset, req_ready is high and mem_req, done_valid and root_wr_denied are low. done_valid is a single-cycle pulse per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| root_wr_en | input | 1 | Request to load the root frame |
| root_wr_frame | input | 20 | New directory base frame number |
| root_wr_ring | input | 2 | Privilege ring of the root write |
| root_wr_denied | output | 1 | Pulses the cycle after a root write from a ring other than 0 |
| req_valid | input | 1 | Start a translation (accepted when req_ready is high) |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_ring | input | 2 | Privilege ring of the access |
| req_ready | output | 1 | Walker idle and able to accept a request |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Memory transaction is a write |
| mem_addr | output | 32 | Byte address of the entry word |
| mem_wdata | output | 32 | Write-back entry value |
| mem_ack | input | 1 | Transaction completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| done_valid | output | 1 | One-cycle result strobe |
| done_fault | output | 1 | Walk ended in a page fault |
| done_fcode | output | 3 | Fault level (bit 2) and cause (bits 1:0) |
| done_paddr | output | 32 | Translated physical address, 0 on a fault |

## Verification
Some properties hold in every cycle, and the embedded assertions watch those. They check that a pending memory request holds its address and data until acknowledged. They check that written-back words always have the present and accessed bits on and are never issued on a faulting walk. They also check that the result strobe is a single cycle with a fault code consistent with the fault flag, and that root writes are accepted or refused according to ring. Only the bench's scenarios can show the rest. That covers the exact directory and table addresses fetched, the resulting physical address, the level and cause chosen among competing permission failures, and the number, order and contents of write-backs for each combination of accessed and dirty bits.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  // Flag bit positions inside a translation entry
  localparam int unsigned FLG_PRESENT  = 0;
  localparam int unsigned FLG_WRITE    = 1;
  localparam int unsigned FLG_USER     = 2;
  localparam int unsigned FLG_ACCESSED = 5;
  localparam int unsigned FLG_DIRTY    = 6;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_ABSENT = 2'b01,
    CAUSE_WPROT  = 2'b10,
    CAUSE_UPRIV  = 2'b11
  } cause_e;

  typedef struct packed {
    logic   tbl_level;
    cause_e cause;
  } fcode_t;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_DIR_RD,
    WS_TBL_RD,
    WS_DIR_WB,
    WS_TBL_WB,
    WS_DONE
  } wstate_e;

endpackage

// File: rtl/pgw_root_reg.sv
module pgw_root_reg #(
  parameter int unsigned FRAME_W = 20,
  parameter int unsigned RING_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic [RING_W-1:0]  wr_ring,
  output logic [FRAME_W-1:0] root_frame,
  output logic               denied
);

  logic priv_ok;
  logic load_en;
  logic denied_d;

  assign priv_ok  = (wr_ring == '0);
  assign load_en  = wr_en && priv_ok;
  assign denied_d = wr_en && !priv_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_frame <= '0;
    end else if (load_en) begin
      root_frame <= wr_frame;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      denied <= 1'b0;
    end else begin
      denied <= denied_d;
    end
  end

  // R3: unprivileged writes leave the root alone and raise the flag
  a_r3_refuse_unpriv: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_ring != '0)) |=> ($stable(root_frame) && denied));

  // R3: ring-0 writes land and are not flagged
  a_r3_accept_ring0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_ring == '0)) |=> ((root_frame == $past(wr_frame)) && !denied));

endmodule

// File: rtl/pgw_perm_check.sv
module pgw_perm_check
  import pgw_pkg::*;
#(
  parameter int unsigned ENT_W = 32
) (
  input  logic [ENT_W-1:0] dir_ent,
  input  logic [ENT_W-1:0] tbl_ent,
  input  logic             is_write,
  input  logic             is_user,
  output logic             perm_fault,
  output fcode_t           perm_code,
  output logic             dir_wb,
  output logic             tbl_wb,
  output logic [ENT_W-1:0] dir_wdata,
  output logic [ENT_W-1:0] tbl_wdata
);

  localparam logic [ENT_W-1:0] MASK_A = ENT_W'(1) << FLG_ACCESSED;
  localparam logic [ENT_W-1:0] MASK_D = ENT_W'(1) << FLG_DIRTY;

  logic dir_user_miss;
  logic tbl_user_miss;
  logic dir_wr_miss;
  logic tbl_wr_miss;

  assign dir_user_miss = is_user  && !dir_ent[FLG_USER];
  assign tbl_user_miss = is_user  && !tbl_ent[FLG_USER];
  assign dir_wr_miss   = is_write && !dir_ent[FLG_WRITE];
  assign tbl_wr_miss   = is_write && !tbl_ent[FLG_WRITE];

  // Privilege failures outrank write-protect failures; directory outranks table
  always_comb begin
    perm_fault = 1'b1;
    perm_code  = '{tbl_level: 1'b0, cause: CAUSE_NONE};
    if (dir_user_miss) begin
      perm_code = '{tbl_level: 1'b0, cause: CAUSE_UPRIV};
    end else if (tbl_user_miss) begin
      perm_code = '{tbl_level: 1'b1, cause: CAUSE_UPRIV};
    end else if (dir_wr_miss) begin
      perm_code = '{tbl_level: 1'b0, cause: CAUSE_WPROT};
    end else if (tbl_wr_miss) begin
      perm_code = '{tbl_level: 1'b1, cause: CAUSE_WPROT};
    end else begin
      perm_fault = 1'b0;
    end
  end

  // Accessed/dirty update words: only the tracking bits are forced on
  assign dir_wb    = !dir_ent[FLG_ACCESSED];
  assign tbl_wb    = !tbl_ent[FLG_ACCESSED] || (is_write && !tbl_ent[FLG_DIRTY]);
  assign dir_wdata = dir_ent | MASK_A;
  assign tbl_wdata = tbl_ent | MASK_A | (is_write ? MASK_D : '0);

endmodule

// File: rtl/pgw_walk_fsm.sv
module pgw_walk_fsm
  import pgw_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned DIR_W  = 10,
  parameter int unsigned TBL_W  = 10,
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned RING_W = 2,
  localparam int unsigned FRAME_W = VA_W - OFS_W,
  localparam int unsigned ENT_W   = VA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  input  logic [RING_W-1:0]  req_ring,
  output logic               req_ready,
  input  logic [FRAME_W-1:0] root_frame,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ENT_W-1:0]   mem_addr,
  output logic [ENT_W-1:0]   mem_wdata,
  input  logic               mem_ack,
  input  logic [ENT_W-1:0]   mem_rdata,
  output logic [ENT_W-1:0]   chk_dir_ent,
  output logic [ENT_W-1:0]   chk_tbl_ent,
  output logic               chk_write,
  output logic               chk_user,
  input  logic               chk_fault,
  input  fcode_t             chk_code,
  input  logic               chk_dir_wb,
  input  logic               chk_tbl_wb,
  input  logic [ENT_W-1:0]   chk_dir_wdata,
  input  logic [ENT_W-1:0]   chk_tbl_wdata,
  output logic               done_valid,
  output logic               done_fault,
  output logic [2:0]         done_fcode,
  output logic [VA_W-1:0]    done_paddr
);

  localparam int unsigned IDX_SH = 2;  // four bytes per entry

  wstate_e              state_q, state_d;
  logic [VA_W-1:0]      va_q;
  logic                 wr_q;
  logic                 user_q;
  logic [FRAME_W-1:0]   root_lat_q;
  logic [ENT_W-1:0]     pde_q;
  logic [ENT_W-1:0]     pte_q;
  logic                 fault_q, fault_d;
  fcode_t               code_q, code_d;
  logic [VA_W-1:0]      pa_q, pa_d;

  logic                 accept_en;
  logic                 pde_en;
  logic                 pte_en;
  logic                 res_en;
  logic [ENT_W-1:0]     dir_addr;
  logic [ENT_W-1:0]     tbl_addr;

  assign accept_en = (state_q == WS_IDLE) && req_valid;
  assign pde_en    = (state_q == WS_DIR_RD) && mem_ack;
  assign pte_en    = (state_q == WS_TBL_RD) && mem_ack;

  assign dir_addr = {root_lat_q, {OFS_W{1'b0}}}
                  + (ENT_W'(va_q[VA_W-1 -: DIR_W]) << IDX_SH);
  assign tbl_addr = {pde_q[ENT_W-1 -: FRAME_W], {OFS_W{1'b0}}}
                  + (ENT_W'(va_q[OFS_W +: TBL_W]) << IDX_SH);

  // Permission checker sees the fresh table word in the read cycle
  assign chk_dir_ent = pde_q;
  assign chk_tbl_ent = (state_q == WS_TBL_RD) ? mem_rdata : pte_q;
  assign chk_write   = wr_q;
  assign chk_user    = user_q;

  // Next-state and result logic
  always_comb begin
    state_d = state_q;
    res_en  = 1'b0;
    fault_d = fault_q;
    code_d  = code_q;
    pa_d    = pa_q;
    unique case (state_q)
      WS_IDLE: begin
        if (req_valid) begin
          state_d = WS_DIR_RD;
          res_en  = 1'b1;
          fault_d = 1'b0;
          code_d  = '{tbl_level: 1'b0, cause: CAUSE_NONE};
          pa_d    = '0;
        end
      end
      WS_DIR_RD: begin
        if (mem_ack) begin
          if (!mem_rdata[FLG_PRESENT]) begin
            state_d = WS_DONE;
            res_en  = 1'b1;
            fault_d = 1'b1;
            code_d  = '{tbl_level: 1'b0, cause: CAUSE_ABSENT};
          end else begin
            state_d = WS_TBL_RD;
          end
        end
      end
      WS_TBL_RD: begin
        if (mem_ack) begin
          res_en = 1'b1;
          if (!mem_rdata[FLG_PRESENT]) begin
            state_d = WS_DONE;
            fault_d = 1'b1;
            code_d  = '{tbl_level: 1'b1, cause: CAUSE_ABSENT};
          end else if (chk_fault) begin
            state_d = WS_DONE;
            fault_d = 1'b1;
            code_d  = chk_code;
          end else begin
            pa_d = {mem_rdata[ENT_W-1 -: FRAME_W], va_q[OFS_W-1:0]};
            if (chk_dir_wb) begin
              state_d = WS_DIR_WB;
            end else if (chk_tbl_wb) begin
              state_d = WS_TBL_WB;
            end else begin
              state_d = WS_DONE;
            end
          end
        end
      end
      WS_DIR_WB: begin
        if (mem_ack) begin
          state_d = chk_tbl_wb ? WS_TBL_WB : WS_DONE;
        end
      end
      WS_TBL_WB: begin
        if (mem_ack) begin
          state_d = WS_DONE;
        end
      end
      WS_DONE: begin
        state_d = WS_IDLE;
      end
      default: begin
        state_d = WS_IDLE;
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q       <= '0;
      wr_q       <= 1'b0;
      user_q     <= 1'b0;
      root_lat_q <= '0;
    end else if (accept_en) begin
      va_q       <= req_vaddr;
      wr_q       <= req_write;
      user_q     <= (req_ring == '1);
      root_lat_q <= root_frame;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pde_q <= '0;
    end else if (pde_en) begin
      pde_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pte_q <= '0;
    end else if (pte_en) begin
      pte_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      code_q  <= '{tbl_level: 1'b0, cause: CAUSE_NONE};
      pa_q    <= '0;
    end else if (res_en) begin
      fault_q <= fault_d;
      code_q  <= code_d;
      pa_q    <= pa_d;
    end
  end

  // Memory port
  always_comb begin
    mem_req   = (state_q == WS_DIR_RD) || (state_q == WS_TBL_RD) ||
                (state_q == WS_DIR_WB) || (state_q == WS_TBL_WB);
    mem_we    = (state_q == WS_DIR_WB) || (state_q == WS_TBL_WB);
    mem_addr  = ((state_q == WS_DIR_RD) || (state_q == WS_DIR_WB)) ? dir_addr : tbl_addr;
    mem_wdata = (state_q == WS_DIR_WB) ? chk_dir_wdata :
                (state_q == WS_TBL_WB) ? chk_tbl_wdata : '0;
  end

  assign req_ready  = (state_q == WS_IDLE);
  assign done_valid = (state_q == WS_DONE);
  assign done_fault = fault_q;
  assign done_fcode = code_q;
  assign done_paddr = fault_q ? '0 : pa_q;

  // R10: a pending request holds still until acknowledged
  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R10: no memory traffic while the walker advertises readiness
  a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

  // R11: result strobe lasts one cycle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  // R4: a reported fault always names a cause
  a_r4_fault_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_fault) |-> (done_fcode[1:0] != 2'b00));

  // R2: a clean translation carries a zero code
  a_r2_clean_code: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_fault) |-> (done_fcode == 3'b000));

  // R8: write-backs only follow a walk that found no fault
  a_r8_wb_only_clean: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !fault_q);

  // R9: a written-back word is present and marked accessed
  a_r9_wb_word: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[FLG_PRESENT] && mem_wdata[FLG_ACCESSED]));

endmodule

// File: rtl/pgw_top.sv
module pgw_top
  import pgw_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned DIR_W  = 10,
  parameter int unsigned TBL_W  = 10,
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned RING_W = 2,
  localparam int unsigned FRAME_W = VA_W - OFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               root_wr_en,
  input  logic [FRAME_W-1:0] root_wr_frame,
  input  logic [RING_W-1:0]  root_wr_ring,
  output logic               root_wr_denied,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  input  logic [RING_W-1:0]  req_ring,
  output logic               req_ready,
  output logic               mem_req,
  output logic               mem_we,
  output logic [VA_W-1:0]    mem_addr,
  output logic [VA_W-1:0]    mem_wdata,
  input  logic               mem_ack,
  input  logic [VA_W-1:0]    mem_rdata,
  output logic               done_valid,
  output logic               done_fault,
  output logic [2:0]         done_fcode,
  output logic [VA_W-1:0]    done_paddr
);

  // Reset: asserted at once, released on a clock edge after two stages
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [FRAME_W-1:0] root_frame;
  logic [VA_W-1:0]    chk_dir_ent;
  logic [VA_W-1:0]    chk_tbl_ent;
  logic               chk_write;
  logic               chk_user;
  logic               chk_fault;
  fcode_t             chk_code;
  logic               chk_dir_wb;
  logic               chk_tbl_wb;
  logic [VA_W-1:0]    chk_dir_wdata;
  logic [VA_W-1:0]    chk_tbl_wdata;

  pgw_root_reg #(
    .FRAME_W (FRAME_W),
    .RING_W  (RING_W)
  ) u_root (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (root_wr_en),
    .wr_frame   (root_wr_frame),
    .wr_ring    (root_wr_ring),
    .root_frame (root_frame),
    .denied     (root_wr_denied)
  );

  pgw_perm_check #(
    .ENT_W (VA_W)
  ) u_perm (
    .dir_ent    (chk_dir_ent),
    .tbl_ent    (chk_tbl_ent),
    .is_write   (chk_write),
    .is_user    (chk_user),
    .perm_fault (chk_fault),
    .perm_code  (chk_code),
    .dir_wb     (chk_dir_wb),
    .tbl_wb     (chk_tbl_wb),
    .dir_wdata  (chk_dir_wdata),
    .tbl_wdata  (chk_tbl_wdata)
  );

  pgw_walk_fsm #(
    .VA_W   (VA_W),
    .DIR_W  (DIR_W),
    .TBL_W  (TBL_W),
    .OFS_W  (OFS_W),
    .RING_W (RING_W)
  ) u_walk (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_write     (req_write),
    .req_ring      (req_ring),
    .req_ready     (req_ready),
    .root_frame    (root_frame),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata),
    .chk_dir_ent   (chk_dir_ent),
    .chk_tbl_ent   (chk_tbl_ent),
    .chk_write     (chk_write),
    .chk_user      (chk_user),
    .chk_fault     (chk_fault),
    .chk_code      (chk_code),
    .chk_dir_wb    (chk_dir_wb),
    .chk_tbl_wb    (chk_tbl_wb),
    .chk_dir_wdata (chk_dir_wdata),
    .chk_tbl_wdata (chk_tbl_wdata),
    .done_valid    (done_valid),
    .done_fault    (done_fault),
    .done_fcode    (done_fcode),
    .done_paddr    (done_paddr)
  );

endmodule

// File: tb/sim_pgw_top.sv
module sim_pgw_top;

  logic        clk;
  logic        rst_n;
  logic        root_wr_en;
  logic [19:0] root_wr_frame;
  logic [1:0]  root_wr_ring;
  logic        root_wr_denied;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic        req_write;
  logic [1:0]  req_ring;
  logic        req_ready;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic        done_valid;
  logic        done_fault;
  logic [2:0]  done_fcode;
  logic [31:0] done_paddr;

  pgw_top u0 (
    .clk(clk), .rst_n(rst_n),
    .root_wr_en(root_wr_en), .root_wr_frame(root_wr_frame),
    .root_wr_ring(root_wr_ring), .root_wr_denied(root_wr_denied),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
    .req_ring(req_ring), .req_ready(req_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done_valid(done_valid), .done_fault(done_fault),
    .done_fcode(done_fcode), .done_paddr(done_paddr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // ---------------- memory model: ack one cycle after request ----------------
  logic [31:0] mem [int unsigned];

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
    end else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
      if (mem_we) mem[mem_addr] = mem_wdata;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // ---------------- transaction log and hold monitor ----------------
  logic [31:0] ra [4];
  logic [31:0] wa [4];
  logic [31:0] wd [4];
  int rn = 0;
  int wn = 0;
  int hold_err = 0;
  bit prev_pend = 0;
  logic [31:0] prev_addr = '0;

  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        if (wn < 4) begin wa[wn] = mem_addr; wd[wn] = mem_wdata; end
        wn++;
      end else begin
        if (rn < 4) ra[rn] = mem_addr;
        rn++;
      end
    end
    if (prev_pend && (!mem_req || mem_addr != prev_addr)) hold_err++;
    prev_pend = mem_req && !mem_ack;
    prev_addr = mem_addr;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  logic        r_fault;
  logic [2:0]  r_fcode;
  logic [31:0] r_paddr;

  task automatic do_walk(input logic [31:0] va, input logic wr, input logic [1:0] ring);
    rn = 0; wn = 0;
    req_vaddr = va; req_write = wr; req_ring = ring; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R10 busy during walk", {31'b0, req_ready}, 32'h0);
    for (int i = 0; i < 40 && !done_valid; i++) @(negedge clk);
    r_fault = done_fault; r_fcode = done_fcode; r_paddr = done_paddr;
    check(done_valid == 1'b1, "R11 result strobe", {31'b0, done_valid}, 32'h1);
    @(negedge clk);
    check(done_valid == 1'b0, "R11 single pulse", {31'b0, done_valid}, 32'h0);
  endtask

  task automatic root_write(input logic [19:0] fr, input logic [1:0] ring);
    root_wr_frame = fr; root_wr_ring = ring; root_wr_en = 1'b1;
    @(negedge clk);
    root_wr_en = 1'b0;
  endtask

  // ---------------- vector table ----------------
  typedef struct packed {
    logic [9:0]  k;     // used as both directory and table index
    logic [11:0] off;
    logic        wr;
    logic [1:0]  ring;
    logic [31:0] pde;
    logic [31:0] pte;
    logic [2:0]  fc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{10'd1,  12'h123, 1'b0, 2'd0, 32'h0002_0003, 32'h1234_5003, 3'b000},
    '{10'd2,  12'hABC, 1'b1, 2'd3, 32'h0002_1027, 32'hABCD_E007, 3'b000},
    '{10'd3,  12'hFFF, 1'b0, 2'd3, 32'h0002_2027, 32'h5555_5E65, 3'b000},
    '{10'd4,  12'h000, 1'b0, 2'd0, 32'h0002_3006, 32'h0000_0000, 3'b001},
    '{10'd5,  12'h010, 1'b0, 2'd0, 32'h0002_4007, 32'h6666_6006, 3'b101},
    '{10'd6,  12'h020, 1'b0, 2'd3, 32'h0002_5003, 32'h7777_7007, 3'b011},
    '{10'd7,  12'h030, 1'b0, 2'd3, 32'h0002_6007, 32'h8888_8003, 3'b111},
    '{10'd8,  12'h040, 1'b1, 2'd0, 32'h0002_7005, 32'h9999_9007, 3'b010},
    '{10'd9,  12'h050, 1'b1, 2'd1, 32'h0002_8007, 32'hAAAA_A005, 3'b110},
    '{10'd10, 12'h060, 1'b1, 2'd3, 32'h0002_9001, 32'h1111_1001, 3'b011},
    '{10'd11, 12'h070, 1'b0, 2'd2, 32'h0002_A001, 32'hBBBB_B001, 3'b000},
    '{10'd12, 12'h080, 1'b1, 2'd0, 32'h0002_B023, 32'hCCCC_CE23, 3'b000}
  };

  localparam logic [31:0] ROOT0 = 32'h0001_0000;

  // ---------------- watchdog ----------------
  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual %h expected %h", 32'd20000, 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    rst_n = 1'b0;
    root_wr_en = 1'b0; root_wr_frame = '0; root_wr_ring = '0;
    req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_ring = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    check(req_ready == 1'b1, "R11 reset ready", {31'b0, req_ready}, 32'h1);
    check(mem_req == 1'b0, "R11 reset mem_req", {31'b0, mem_req}, 32'h0);
    check(done_valid == 1'b0, "R11 reset done", {31'b0, done_valid}, 32'h0);
    check(root_wr_denied == 1'b0, "R11 reset denied", {31'b0, root_wr_denied}, 32'h0);

    root_write(ROOT0[31:12], 2'd0);
    @(negedge clk);

    foreach (VECS[n]) begin
      vec_t v;
      logic [31:0] va, daddr, taddr, exp_pa;
      int exp_wn;
      logic [31:0] ewa [2];
      logic [31:0] ewd [2];
      string ftag;
      v = VECS[n];
      va    = {v.k, v.k, v.off};
      daddr = ROOT0 + {20'b0, v.k, 2'b00};
      taddr = {v.pde[31:12], 12'h000} + {20'b0, v.k, 2'b00};
      mem[daddr] = v.pde;
      mem[taddr] = v.pte;
      do_walk(va, v.wr, v.ring);

      case (v.fc[1:0])
        2'b00:   ftag = "R2 clean walk";
        2'b01:   ftag = "R4 not-present";
        2'b10:   ftag = "R6 write-protect";
        default: ftag = "R5 user-privilege";
      endcase
      check(r_fcode == v.fc, ftag, {29'b0, r_fcode}, {29'b0, v.fc});
      check(r_fault == (v.fc != 3'b000), ftag, {31'b0, r_fault}, {31'b0, (v.fc != 3'b000)});
      exp_pa = (v.fc == 3'b000) ? {v.pte[31:12], v.off} : 32'h0;
      check(r_paddr == exp_pa, (v.fc == 3'b000) ? "R2 physical address" : "R4 zero address on fault",
            r_paddr, exp_pa);

      // R1: fetch addresses
      check(ra[0] == daddr, "R1 directory address", ra[0], daddr);
      if (v.pde[0]) begin
        check(rn == 2 && ra[1] == taddr, "R1 table address", ra[1], taddr);
      end else begin
        check(rn == 1, "R4 no table read after absent directory", rn, 32'd1);
      end

      // R7/R8/R9: write-backs
      exp_wn = 0;
      if (v.fc == 3'b000) begin
        if (!v.pde[5]) begin ewa[exp_wn] = daddr; ewd[exp_wn] = v.pde | 32'h20; exp_wn++; end
        if (!v.pte[5] || (v.wr && !v.pte[6])) begin
          ewa[exp_wn] = taddr; ewd[exp_wn] = v.pte | 32'h20 | (v.wr ? 32'h40 : 32'h0); exp_wn++;
        end
      end
      check(wn == exp_wn, (exp_wn == 0) ? "R8 no redundant write" : "R7 write-back count", wn, exp_wn);
      for (int j = 0; j < exp_wn && j < wn; j++) begin
        check(wa[j] == ewa[j], "R7 write-back address/order", wa[j], ewa[j]);
        check(wd[j] == ewd[j], "R9 write-back data preserved", wd[j], ewd[j]);
      end
      @(negedge clk);
    end

    // R3: unprivileged root write is refused and flagged
    root_wr_frame = 20'h00050; root_wr_ring = 2'd3; root_wr_en = 1'b1;
    @(negedge clk);
    root_wr_en = 1'b0;
    check(root_wr_denied == 1'b1, "R3 denied flag", {31'b0, root_wr_denied}, 32'h1);
    @(negedge clk);
    check(root_wr_denied == 1'b0, "R3 denied flag one cycle", {31'b0, root_wr_denied}, 32'h0);
    do_walk({10'd1, 10'd1, 12'h004}, 1'b0, 2'd0);
    check(ra[0] == ROOT0 + 32'h4, "R3 root unchanged after ring-3 write", ra[0], ROOT0 + 32'h4);
    check(wn == 0, "R8 accessed bits already set", wn, 32'd0);
    @(negedge clk);

    // R3: ring-0 write takes effect
    root_write(20'h00060, 2'd0);
    check(root_wr_denied == 1'b0, "R3 ring-0 write not flagged", {31'b0, root_wr_denied}, 32'h0);
    mem[32'h0006_0034] = 32'h0002_C003;
    mem[32'h0002_C034] = 32'h0DDD_D003;
    do_walk({10'd13, 10'd13, 12'h5A5}, 1'b0, 2'd0);
    check(ra[0] == 32'h0006_0034, "R3 new root used", ra[0], 32'h0006_0034);
    check(r_paddr == 32'h0DDD_D5A5, "R2 address under new root", r_paddr, 32'h0DDD_D5A5);

    check(hold_err == 0, "R10 request held until ack", hold_err, 32'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule